// File: doc/BRIEF.md
# Four-Channel Scaled-Compare PWM Timer

A single free-running counter drives four compare channels through a shifted 16-bit window. A 4-bit scale field in the configuration register selects the shift, so the compared value is the counter divided by a power of two. Each channel asserts its compare output while the windowed value is at or above that channel's threshold. A channel can fold its window about the midpoint to give centre-aligned pulses. It can also be paired with the next channel so that its output marks only the span between the two thresholds.

Software reaches the block through a word-addressed register port. The port has a one-cycle write strobe and a combinational read path. The counter runs continuously, or in one-shot mode, where it stops itself when the window saturates or when channel 0 matches. A rising compare edge on any channel latches a sticky pending bit, and that bit drives the channel's interrupt line until software clears it. Channel 0 can also act as the period register: when enabled, a match on it sends the counter back to zero.

Top module: `pwm_timer`

## Requirements
- R1: After reset (asynchronous, active-low `rst_ni`), the counter, configuration, all four thresholds, `cmp_o` and `irq_o` are zero.
- R2: The counter steps by one per clock when configuration bit 12 (run continuously) or bit 13 (one-shot) is set. When neither bit is set, the counter keeps its value.
- R3: Reading address 4 returns (counter >> scale) & 0xFFFF, where scale is configuration bits [3:0]. A write to address 4 changes neither the counter nor that value.
- R4: While the counter runs and the window equals 0xFFFF, the counter becomes zero on the next clock and bit 13 is cleared.
- R5: Channel i is active when the counter runs and its compared value is greater than or equal to threshold i. `cmp_o[i]` follows that state when pairing is off, and all outputs are low while the counter is stopped.
- R6: When configuration bit 16+i is set, channel i compares the bitwise inverse of the window whenever window bit 15 is set, and compares the window itself otherwise.
- R7: An active channel 0 clears bit 13 on the next clock. When configuration bit 9 is also set, it sends the counter to zero on the next clock.
- R8: When configuration bit 24+i is set, `cmp_o[i]` is active(i) AND NOT active((i+1) mod 4).
- R9: A rising edge of active(i) sets configuration bit 28+i. That bit drives `irq_o[i]`, holds until software writes it to zero, and is not set by a channel that stays active.
- R10: A write to address 2 loads the counter from `wdata_i[30:0]`. A read of address 2 returns the live count.
- R11: A software write to the configuration register wins over a hardware clear of bit 13 and over a pending-bit set in the same cycle.
- R12: Addresses 8 to 11 hold thresholds 0 to 3 (16 bits, read back zero-extended). Address 0 holds the configuration. Every other address reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | One-cycle write strobe |
| addr_i | input | 4 | Word address for read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| cmp_o | output | 4 | Compare outputs after optional pairing |
| irq_o | output | 4 | Sticky pending flags, one per channel |

## Verification
The assertions assume that each write strobe is meant for exactly one register in its cycle. The counter-step, wrap and sticky-flag properties are therefore guarded by the absence of a counter write or a configuration write in that cycle, and they say nothing about cycles where software overrides the hardware. They also assume that `addr_i` and `wdata_i` are steady around the rising edge. The bench respects both assumptions: it changes every input on the falling edge and raises `we_i` for one cycle per access. Between writes it lets the counter free-run, so that windows with and without writes are both exercised.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int NUM_CH  = 4;
  localparam int WIN_W   = 16;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 32;

  localparam logic [ADDR_W-1:0] A_CFG    = 4'd0;
  localparam logic [ADDR_W-1:0] A_CNT    = 4'd2;
  localparam logic [ADDR_W-1:0] A_SCALED = 4'd4;
  localparam logic [ADDR_W-1:0] A_CMP0   = 4'd8;

  localparam int CFG_ZCMP    = 9;
  localparam int CFG_ALWAYS  = 12;
  localparam int CFG_ONESHOT = 13;
  localparam int CFG_CTR_LSB = 16;
  localparam int CFG_GANG_LSB = 24;
  localparam int CFG_PEND_LSB = 28;
endpackage

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W   = 31,
  parameter int SCALE_W = 4,
  parameter int WIN_W   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               zero_i,
  input  logic               ld_i,
  input  logic [CNT_W-1:0]   ld_val_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [WIN_W-1:0]   win_o,
  output logic               wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] shifted;

  assign shifted = cnt_q >> scale_i;
  assign win_o   = shifted[WIN_W-1:0];
  assign wrap_o  = &win_o;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (ld_i)          cnt_q <= ld_val_i;
    else if (en_i) begin
      if (wrap_o || zero_i) cnt_q <= '0;
      else                  cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/pwm_cmp_ch.sv
module pwm_cmp_ch #(
  parameter int WIN_W = 16
) (
  input  logic             en_i,
  input  logic             center_i,
  input  logic [WIN_W-1:0] win_i,
  input  logic [WIN_W-1:0] thr_i,
  output logic             act_o
);
  logic [WIN_W-1:0] folded;

  // fold the upper half back down for centre-aligned pulses
  assign folded = (center_i && win_i[WIN_W-1]) ? ~win_i : win_i;
  assign act_o  = en_i && (folded >= thr_i);
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W   = 31,
  parameter int SCALE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] cmp_o,
  output logic [NUM_CH-1:0] irq_o
);
  localparam int CH_IDX_W = $clog2(NUM_CH);

  logic [DATA_W-1:0] cfg_q;
  logic [WIN_W-1:0]  thr_q [NUM_CH];
  logic [CNT_W-1:0]  cnt_q;
  logic [WIN_W-1:0]  win;
  logic              wrap;
  logic [NUM_CH-1:0] act, act_q, rise;
  logic              en, cfg_wr, cnt_wr, os_clr;

  assign en     = cfg_q[CFG_ALWAYS] | cfg_q[CFG_ONESHOT];
  assign cfg_wr = we_i && (addr_i == A_CFG);
  assign cnt_wr = we_i && (addr_i == A_CNT);
  assign rise   = act & ~act_q;
  assign os_clr = en && (wrap || act[0]);

  pwm_counter #(.CNT_W(CNT_W), .SCALE_W(SCALE_W), .WIN_W(WIN_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en),
    .zero_i   (cfg_q[CFG_ZCMP] && act[0]),
    .ld_i     (cnt_wr),
    .ld_val_i (wdata_i[CNT_W-1:0]),
    .scale_i  (cfg_q[SCALE_W-1:0]),
    .cnt_o    (cnt_q),
    .win_o    (win),
    .wrap_o   (wrap)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int NXT = (i + 1) % NUM_CH;

    pwm_cmp_ch #(.WIN_W(WIN_W)) u_ch (
      .en_i     (en),
      .center_i (cfg_q[CFG_CTR_LSB+i]),
      .win_i    (win),
      .thr_i    (thr_q[i]),
      .act_o    (act[i])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                        thr_q[i] <= '0;
      else if (we_i && addr_i == A_CMP0 + ADDR_W'(i))     thr_q[i] <= wdata_i[WIN_W-1:0];
    end

    assign cmp_o[i] = cfg_q[CFG_GANG_LSB+i] ? (act[i] & ~act[NXT]) : act[i];
    assign irq_o[i] = cfg_q[CFG_PEND_LSB+i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= '0;
    else         act_q <= act;
  end

  // software write beats hardware set/clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (cfg_wr) cfg_q <= wdata_i;
    else begin
      if (os_clr) cfg_q[CFG_ONESHOT] <= 1'b0;
      for (int i = 0; i < NUM_CH; i++)
        if (rise[i]) cfg_q[CFG_PEND_LSB+i] <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CFG)         rdata_o = cfg_q;
    else if (addr_i == A_CNT)    rdata_o[CNT_W-1:0] = cnt_q;
    else if (addr_i == A_SCALED) rdata_o[WIN_W-1:0] = win;
    else if (addr_i[ADDR_W-1:CH_IDX_W] == A_CMP0[ADDR_W-1:CH_IDX_W])
      rdata_o[WIN_W-1:0] = thr_q[addr_i[CH_IDX_W-1:0]];
  end
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 31
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] cfg_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              wrap,
  input logic [NUM_CH-1:0] act,
  input logic [NUM_CH-1:0] cmp_o,
  input logic [NUM_CH-1:0] irq_o
);
  logic run, cnt_wr, cfg_wr, zcmp_hit;
  assign run      = cfg_q[CFG_ALWAYS] | cfg_q[CFG_ONESHOT];
  assign cnt_wr   = we_i && (addr_i == A_CNT);
  assign cfg_wr   = we_i && (addr_i == A_CFG);
  assign zcmp_hit = cfg_q[CFG_ZCMP] && act[0];

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_wr && !run) |=> (cnt_q == $past(cnt_q))); // R2
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_wr && run && !wrap && !zcmp_hit) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_wr && run && wrap) |=> (cnt_q == '0)); // R4
  AST_ZCMP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_wr && run && zcmp_hit) |=> (cnt_q == '0)); // R7
  AST_OS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_wr && run && act[0]) |=> !cfg_q[CFG_ONESHOT]); // R7
  AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_wr |=> ((irq_o & $past(irq_o)) == $past(irq_o))); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> (cmp_o == '0)); // R5
  AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> (cnt_q == $past(wdata_i[CNT_W-1:0]))); // R10
endmodule

bind pwm_timer pwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .cfg_q   (cfg_q),
  .cnt_q   (cnt_q),
  .wrap    (wrap),
  .act     (act),
  .cmp_o   (cmp_o),
  .irq_o   (irq_o)
);

// File: tb/sim_pwm_timer.sv
`timescale 1ns/1ps
module sim_pwm_timer;
  localparam logic [31:0] RUN  = 32'h1 << 12;
  localparam logic [31:0] ONE  = 32'h1 << 13;
  localparam logic [31:0] ZCMP = 32'h1 << 9;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [3:0]  cmp_o, irq_o;
  int n_run = 0, n_fail = 0;

  pwm_timer u0 (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  function automatic logic [15:0] bnd(int k);
    case (k)
      0: return 16'h0FFF; 1: return 16'h1000; 2: return 16'h3FFF; 3: return 16'h4000;
      4: return 16'h8FFF; 5: return 16'h9000; 6: return 16'hBFFF; default: return 16'hC000;
    endcase
  endfunction

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [15:0] thr [4];
    thr[0] = 16'h1000; thr[1] = 16'h4000; thr[2] = 16'h9000; thr[3] = 16'hC000;
    tick(3); rst_ni = 1'b1; tick(1);

    // R1 reset state
    foreach (thr[i]) begin rd(4'(8 + i), d); chk("R1 thr", d, 0); end
    rd(0, d); chk("R1 cfg", d, 0);
    rd(2, d); chk("R1 cnt", d, 0);
    rd(4, d); chk("R1 win", d, 0);
    chk("R1 cmp_o", {28'd0, cmp_o}, 0);
    chk("R1 irq_o", {28'd0, irq_o}, 0);

    // R12 map
    for (int i = 0; i < 4; i++) wr(4'(8 + i), 32'h1111 * (i + 1) | 32'hABCD_0000);
    for (int i = 0; i < 4; i++) begin rd(4'(8 + i), d); chk("R12 thr readback", d, 32'h1111 * (i + 1)); end
    foreach (thr[i]) begin end
    rd(1, d); chk("R12 unmapped 1", d, 0);
    rd(3, d); chk("R12 unmapped 3", d, 0);
    rd(15, d); chk("R12 unmapped 15", d, 0);

    // R10 load, R2 hold
    wr(2, 32'h0123_4567); rd(2, d); chk("R10 load", d, 32'h0123_4567);
    tick(5); rd(2, d); chk("R2 hold", d, 32'h0123_4567);

    // R3 window over all scales
    for (int v = 0; v < 2; v++) begin
      logic [30:0] cv = (v == 0) ? 31'h0123_4567 : 31'h7FFF_ABCD;
      wr(2, {1'b0, cv});
      for (int s = 0; s < 16; s++) begin
        wr(0, 32'(s));
        rd(4, d); chk("R3 window", d, 32'((cv >> s) & 31'hFFFF));
      end
    end
    wr(0, 0); wr(2, 32'h0001_2345); wr(4, 32'hFFFF_FFFF);
    rd(2, d); chk("R3 write ignored cnt", d, 32'h0001_2345);
    rd(4, d); chk("R3 write ignored win", d, 32'h2345);

    // R2 stepping
    wr(2, 100); wr(0, RUN);
    rd(2, d); chk("R2 start", d, 100);
    tick(7); rd(2, d); chk("R2 step", d, 107);
    wr(0, 0); rd(2, d); chk("R2 stop", d, 108);
    tick(4); rd(2, d); chk("R2 stopped", d, 108);

    // R4 wrap, one-shot then continuous
    for (int i = 0; i < 4; i++) wr(4'(8 + i), 32'hFFFF);
    wr(2, 32'hFFFD); wr(0, ONE);
    tick(2); rd(4, d); chk("R4 at top", d, 32'hFFFF);
    tick(1); rd(2, d); chk("R4 wrap zero", d, 0);
    rd(0, d); chk("R4 oneshot cleared", d & ONE, 0);
    tick(2); rd(2, d); chk("R4 stopped after wrap", d, 0);
    wr(2, 32'hFFFE); wr(0, RUN);
    tick(2); rd(2, d); chk("R4 run wrap", d, 0);
    tick(1); rd(2, d); chk("R4 run restart", d, 1);

    // R5 idle outputs
    for (int i = 0; i < 4; i++) wr(4'(8 + i), {16'd0, thr[i]});
    wr(0, 0); wr(2, 32'hC000); #1;
    chk("R5 idle outputs", {28'd0, cmp_o}, 0);

    // R5 R6 R8 sweep
    for (int g = 0; g < 2; g++)
      for (int c = 0; c < 2; c++)
        for (int si = 0; si < 2; si++) begin
          int s = si * 3;
          wr(0, RUN | 32'(s) | (g ? 32'hF << 24 : 0) | (c ? 32'hF << 16 : 0));
          for (int k = 0; k < 40; k++) begin
            logic [15:0] v = (k < 32) ? 16'(k * 16'h0800) : bnd(k - 32);
            logic [15:0] f = (c && v[15]) ? ~v : v;
            logic [3:0] a, e;
            for (int i = 0; i < 4; i++) a[i] = (f >= thr[i]);
            for (int i = 0; i < 4; i++) e[i] = g ? (a[i] & ~a[(i + 1) % 4]) : a[i];
            wr(2, 32'(v) << s); #1;
            chk(g ? "R8 paired output" : (c ? "R6 centre fold" : "R5 compare"),
                {28'd0, cmp_o}, {28'd0, e});
          end
        end

    // R7 counter reset on channel-0 match
    wr(0, 0); wr(8, 32'h20);
    for (int i = 1; i < 4; i++) wr(4'(8 + i), 32'hFFFF);
    wr(2, 32'h1E); wr(0, RUN | ZCMP);
    tick(2); rd(2, d); chk("R7 reach match", d, 32'h20);
    tick(1); rd(2, d); chk("R7 zero on match", d, 0);
    tick(1); rd(2, d); chk("R7 resume", d, 1);

    // R7 one-shot stops on match
    wr(0, 0); wr(2, 32'h1E); wr(0, ONE);
    tick(3); rd(2, d); chk("R7 oneshot count", d, 32'h21);
    rd(0, d); chk("R7 oneshot cleared", d & ONE, 0);
    tick(2); rd(2, d); chk("R7 oneshot held", d, 32'h21);

    // R9 sticky pending
    wr(8, 32'h10); wr(0, 0); wr(2, 0); wr(0, RUN);
    tick(16); chk("R9 before edge", {28'd0, irq_o}, 0);
    tick(1); chk("R9 set on edge", {28'd0, irq_o}, 1);
    rd(0, d); chk("R9 cfg bit", d & (32'h1 << 28), 32'h1 << 28);
    tick(3); wr(2, 0); tick(2);
    chk("R9 sticky", {28'd0, irq_o}, 1);
    wr(0, RUN); chk("R9 cleared by write", {28'd0, irq_o}, 0);

    // R11 software write priority
    wr(2, 0); wr(2, 32'h10); wr(0, RUN);
    chk("R11 pending blocked", {28'd0, irq_o}, 0);
    tick(3); chk("R11 no late set", {28'd0, irq_o}, 0);
    wr(0, RUN | ONE);
    rd(0, d); chk("R11 oneshot kept", d & ONE, ONE);
    tick(1); rd(0, d); chk("R7 oneshot hw clear", d & ONE, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule